// File: doc/BRIEF.md
# Integer ALU with Set-on-Condition Compare

This block is the integer execution unit of a 32-bit load-store pipeline. Each operation takes operand A from a register and operand B either from a register or from a 16-bit immediate, and it yields one 32-bit result in the same cycle. The unit adds, subtracts, applies bitwise AND/OR/XOR, shifts left, shifts right logically and shifts right arithmetically. It also builds the upper half of a constant, and it evaluates a relation between its operands. The relation writes a plain 0 or 1, so any destination register can hold it for a later zero/non-zero branch, and no flags register is needed.

The surrounding decoder supplies a function code, a relation code, a signedness select and an immediate select. The unit widens the immediate itself according to the operation, so the decoder passes the raw 16 bits. The path has no register and no trap. An overflow wraps silently.

Top module: `int_exec_unit`

## Requirements
- R1: fn=0 gives A+B and fn=1 gives A-B, both modulo 2^32, with no overflow indication (0x7FFFFFFF+1 = 0x80000000).
- R2: fn=2, 3 and 4 give the bitwise AND, OR and XOR of A and B.
- R3: With use_imm=1, B is the immediate sign-extended for fn=0 and fn=1, and zero-extended for fn=2, 3 and 4.
- R4: For fn=5 (shift left), fn=6 (logical right) and fn=7 (arithmetic right), the shift amount is bits 4:0 of B (register or immediate), and all higher bits of B are ignored.
- R5: A logical right shift fills vacated bits with 0, and an arithmetic right shift fills them with copies of A[31].
- R6: fn=8 returns the 16-bit immediate in bits 31:16 and zeros in bits 15:0, whatever A and B are.
- R7: fn=9 (set on condition) returns exactly 1 when the relation holds and 0 otherwise. Bits 31:1 are always zero.
- R8: The relation codes are 0=EQ, 1=NE, 2=LT, 3=GT, 4=LE, 5=GE, each evaluated as A relation B.
- R9: cmp_unsigned=0 compares as two's-complement and sign-extends an immediate. cmp_unsigned=1 compares as unsigned and zero-extends an immediate.
- R10: Function codes 10 to 15 return 0, and fn=9 with relation code 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn | input | 4 | Function code |
| rel | input | 3 | Relation code for set-on-condition |
| cmp_unsigned | input | 1 | Unsigned compare and zero-extended compare immediate |
| use_imm | input | 1 | Take operand B from the immediate |
| a | input | 32 | Operand A |
| b | input | 32 | Register operand B |
| imm | input | 16 | Raw immediate |
| y | output | 32 | Result |

## Verification
The immediate widening and the relation evaluation both depend on the signedness select, and they act together in the same cycle. A single wrong decision therefore shows up only in their combination. The bench provokes this by comparing A = 0xFFFFFFFF against immediate 0xFFFF. In signed mode the two are equal (-1 against -1). In unsigned mode the immediate becomes 0x0000FFFF and A is greater. The bench judges EQ and GT in both modes. Register-form compares with operands of opposite sign are also swept through all six relations in both modes, and the bench computes each expected bit from its own comparison.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [3:0]   fn,
  input  logic [2:0]   rel,
  input  logic         cmp_unsigned,
  input  logic         use_imm,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0] y
);
  localparam int SW = $clog2(W);

  localparam logic [3:0] F_ADD = 4'd0, F_SUB = 4'd1, F_AND = 4'd2, F_OR  = 4'd3,
                         F_XOR = 4'd4, F_SLL = 4'd5, F_SRL = 4'd6, F_SRA = 4'd7,
                         F_LHI = 4'd8, F_SET = 4'd9;

  logic          sext;
  logic [W-1:0]  opb;
  logic [SW-1:0] shamt;
  logic          is_eq, is_lt, hit;

  assign sext  = (fn == F_ADD) || (fn == F_SUB) || ((fn == F_SET) && !cmp_unsigned);
  assign opb   = !use_imm ? b :
                 sext     ? {{(W-IW){imm[IW-1]}}, imm} : {{(W-IW){1'b0}}, imm};
  assign shamt = opb[SW-1:0];

  assign is_eq = (a == opb);
  assign is_lt = cmp_unsigned ? (a < opb) : ($signed(a) < $signed(opb));

  always_comb begin
    case (rel)
      3'd0:    hit = is_eq;
      3'd1:    hit = !is_eq;
      3'd2:    hit = is_lt;
      3'd3:    hit = !is_lt && !is_eq;
      3'd4:    hit = is_lt || is_eq;
      3'd5:    hit = !is_lt;
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    case (fn)
      F_ADD:   y = a + opb;
      F_SUB:   y = a - opb;
      F_AND:   y = a & opb;
      F_OR:    y = a | opb;
      F_XOR:   y = a ^ opb;
      F_SLL:   y = a << shamt;
      F_SRL:   y = a >> shamt;
      F_SRA:   y = W'($signed(a) >>> shamt);
      F_LHI:   y = {imm, {(W-IW){1'b0}}};
      F_SET:   y = {{(W-1){1'b0}}, hit};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input logic [3:0]    fn,
  input logic [2:0]    rel,
  input logic          cmp_unsigned,
  input logic          use_imm,
  input logic [W-1:0]  a,
  input logic [W-1:0]  b,
  input logic [IW-1:0] imm,
  input logic [W-1:0]  y
);
  always_comb begin
    if (fn == 4'd9)
      AST_SET_IS_BIT: assert (y[W-1:1] == '0) else $error("set result not 0/1"); // R7
    if (fn == 4'd8)
      AST_LHI_SHAPE: assert (y == {imm, {(W-IW){1'b0}}}) else $error("lhi shape"); // R6
    if (fn == 4'd7)
      AST_SRA_SIGN_KEPT: assert (y[W-1] == a[W-1]) else $error("sra sign lost"); // R5
    if (fn == 4'd6 && !use_imm && b[$clog2(W)-1:0] != '0)
      AST_SRL_ZERO_TOP: assert (!y[W-1]) else $error("srl top not zero"); // R5
    if (fn == 4'd1 && !use_imm && a == b)
      AST_SUB_SELF_ZERO: assert (y == '0) else $error("a-a nonzero"); // R1
    if (fn >= 4'd10 || (fn == 4'd9 && rel >= 3'd6))
      AST_RESERVED_ZERO: assert (y == '0) else $error("reserved code nonzero"); // R10
  end
endmodule

bind int_exec_unit int_exec_unit_chk #(.W(W), .IW(IW)) u_chk (
  .fn(fn), .rel(rel), .cmp_unsigned(cmp_unsigned), .use_imm(use_imm),
  .a(a), .b(b), .imm(imm), .y(y)
);

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [3:0]  fn;
  logic [2:0]  rel;
  logic        cmp_unsigned, use_imm;
  logic [31:0] a, b, y;
  logic [15:0] imm;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_unit u0 (.fn(fn), .rel(rel), .cmp_unsigned(cmp_unsigned), .use_imm(use_imm),
                    .a(a), .b(b), .imm(imm), .y(y));

  task automatic apply(input string req, input logic [3:0] f, input logic [2:0] r,
                       input logic u, input logic ui, input logic [31:0] va,
                       input logic [31:0] vb, input logic [15:0] vi, input logic [31:0] exp);
    @(negedge clk);
    fn = f; rel = r; cmp_unsigned = u; use_imm = ui; a = va; b = vb; imm = vi;
    #1;
    n_chk++;
    if (y !== exp) begin
      n_bad++;
      $display("FAIL %s fn=%0d rel=%0d: actual %h expected %h", req, f, r, y, exp);
    end
  endtask

  function automatic logic [31:0] rel_ref(input logic [2:0] r, input logic u,
                                          input logic [31:0] x, input logic [31:0] z);
    longint sx, sz;
    sx = u ? longint'({32'd0, x}) : longint'($signed(x));
    sz = u ? longint'({32'd0, z}) : longint'($signed(z));
    case (r)
      3'd0: return {31'd0, sx == sz};
      3'd1: return {31'd0, sx != sz};
      3'd2: return {31'd0, sx <  sz};
      3'd3: return {31'd0, sx >  sz};
      3'd4: return {31'd0, sx <= sz};
      3'd5: return {31'd0, sx >= sz};
      default: return 32'd0;
    endcase
  endfunction

  task automatic t_idle();
    apply("R1 idle", 4'd0, 3'd0, 0, 0, 32'd0, 32'd0, 16'd0, 32'd0);
  endtask

  task automatic t_arith();
    apply("R1 add wrap", 4'd0, 3'd0, 0, 0, 32'h7FFFFFFF, 32'd1, 16'd0, 32'h80000000);
    apply("R1 sub wrap", 4'd1, 3'd0, 0, 0, 32'd0, 32'd1, 16'd0, 32'hFFFFFFFF);
    apply("R3 addi sext", 4'd0, 3'd0, 0, 1, 32'd10, 32'hDEAD, 16'hFFFF, 32'd9);
    apply("R3 subi sext", 4'd1, 3'd0, 0, 1, 32'd5, 32'd0, 16'h8000, 32'h00008005);
  endtask

  task automatic t_logic();
    apply("R2 and", 4'd2, 3'd0, 0, 0, 32'hF0F0F0F0, 32'hFF00FF00, 16'd0, 32'hF000F000);
    apply("R2 or",  4'd3, 3'd0, 0, 0, 32'hF0F0F0F0, 32'hFF00FF00, 16'd0, 32'hFFF0FFF0);
    apply("R2 xor", 4'd4, 3'd0, 0, 0, 32'hF0F0F0F0, 32'hFF00FF00, 16'd0, 32'h0FF00FF0);
    apply("R3 andi zext", 4'd2, 3'd0, 0, 1, 32'hFFFFFFFF, 32'd0, 16'h8001, 32'h00008001);
    apply("R3 xori zext", 4'd4, 3'd0, 0, 1, 32'd0, 32'd0, 16'hFFFF, 32'h0000FFFF);
  endtask

  task automatic t_shift();
    apply("R4 sll low bits", 4'd5, 3'd0, 0, 0, 32'd1, 32'hFFFFFFE4, 16'd0, 32'h10);
    apply("R5 srl zero fill", 4'd6, 3'd0, 0, 0, 32'h80000000, 32'd31, 16'd0, 32'd1);
    apply("R5 srl nibble", 4'd6, 3'd0, 0, 0, 32'hF0000000, 32'd4, 16'd0, 32'h0F000000);
    apply("R5 sra sign fill", 4'd7, 3'd0, 0, 0, 32'h80000000, 32'd31, 16'd0, 32'hFFFFFFFF);
    apply("R4 srai imm low bits", 4'd7, 3'd0, 0, 1, 32'h40000000, 32'd0, 16'h0021, 32'h20000000);
  endtask

  task automatic t_lhi();
    apply("R6 lhi", 4'd8, 3'd0, 0, 0, 32'h12345678, 32'h9ABCDEF0, 16'hABCD, 32'hABCD0000);
  endtask

  task automatic t_set_reg();
    logic [31:0] pa [3] = '{32'd3, 32'hFFFFFFFF, 32'd1};
    logic [31:0] pb [3] = '{32'd3, 32'd1, 32'hFFFFFFFF};
    for (int u = 0; u < 2; u++)
      for (int r = 0; r < 6; r++)
        for (int k = 0; k < 3; k++)
          apply("R7 R8 R9 set reg", 4'd9, 3'(r), 1'(u), 0, pa[k], pb[k], 16'd0,
                rel_ref(3'(r), 1'(u), pa[k], pb[k]));
  endtask

  task automatic t_set_imm();
    apply("R9 seqi signed",   4'd9, 3'd0, 0, 1, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 32'd1);
    apply("R9 seqi unsigned", 4'd9, 3'd0, 1, 1, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 32'd0);
    apply("R9 sgti unsigned", 4'd9, 3'd3, 1, 1, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 32'd1);
    apply("R9 sgti signed",   4'd9, 3'd3, 0, 1, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 32'd0);
  endtask

  task automatic t_reserved();
    apply("R10 rel 6", 4'd9, 3'd6, 0, 0, 32'd1, 32'd1, 16'd0, 32'd0);
    apply("R10 rel 7", 4'd9, 3'd7, 1, 0, 32'd0, 32'd5, 16'd0, 32'd0);
    apply("R10 fn 15", 4'd15, 3'd0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 32'd0);
  endtask

  initial begin
    fn = '0; rel = '0; cmp_unsigned = 0; use_imm = 0; a = '0; b = '0; imm = '0;
    t_idle();
    t_arith();
    t_logic();
    t_shift();
    t_lhi();
    t_set_reg();
    t_set_imm();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule